// File: doc/BRIEF.md
# Limited-Range Pixel Clamp

This block bounds every colour component of a 12-bit-per-component pixel stream to a video range picked by a 3-bit range code. Three fixed ranges serve content that was originally 8, 10 or 12 bits deep, all expressed on the 12-bit MSB-aligned scale. A fourth choice uses lower and upper bounds supplied separately for each component. With clamping switched off, or when the code names no range, pixels leave the block unchanged.

Each component passes through max(lower, min(upper, x)) and then a register, so results appear one cycle after the input. The valid flag is delayed by the same register. The block sits in the output path of a display pipeline, behind any bit-depth reduction and ahead of the link encoder. The range controls are quasi-static configuration, but they are sampled together with the pixel on every cycle.

Top module: `pix_range_clamp`

## Requirements
- R1: When the reset input is held low, the output valid is 0 and all three output components are 0.
- R2: Each output appears exactly one clock after the corresponding input. Output valid equals input valid delayed by one clock.
- R3: With clamp enable 0, each output component equals its input component delayed by one clock, whatever the range code is.
- R4: With enable 1 and code 0, or with enable 1 and code 4, 5 or 6, the data passes through unchanged.
- R5: With enable 1 and code 1, every component is bounded to the range 256..3760, which is 16..235 shifted left by 4.
- R6: With enable 1 and code 2, every component is bounded to the range 256..3760, which is 64..940 shifted left by 2.
- R7: With enable 1 and code 3, every component is bounded to the range 256..3760.
- R8: With enable 1 and code 7, each component is bounded by its own lower and upper limit inputs.
- R9: In the programmable mode, when a lower limit is greater than its upper limit, that component outputs the upper limit.
- R10: The package defines default programmable limits of 0x010 (lower) and 0xFEF (upper). With those defaults, inputs 0 and 4095 become 16 and 4079.
- R11: The three components are processed independently. A bound on one component never changes another component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input pixel valid |
| in_r | input | 12 | R/Cr component |
| in_g | input | 12 | G/Y component |
| in_b | input | 12 | B/Cb component |
| clamp_en | input | 1 | Clamp enable |
| range_code | input | 3 | 0 pass, 1 8-bit, 2 10-bit, 3 12-bit, 7 programmable, other codes pass |
| lim_lo_r | input | 12 | Programmable lower limit, R |
| lim_hi_r | input | 12 | Programmable upper limit, R |
| lim_lo_g | input | 12 | Programmable lower limit, G |
| lim_hi_g | input | 12 | Programmable upper limit, G |
| lim_lo_b | input | 12 | Programmable lower limit, B |
| lim_hi_b | input | 12 | Programmable upper limit, B |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 12 | Bounded R/Cr |
| out_g | output | 12 | Bounded G/Y |
| out_b | output | 12 | Bounded B/Cb |

## Verification
The block holds no state apart from its output register. A bad bound selection or a swapped min/max order therefore shows up at the ports on the very next clock, as a component that lies outside its selected range or that differs from its input in pass-through. Because every result depends only on the previous cycle's inputs, the bench compares every cycle against a one-cycle-delayed model. That comparison catches a wrong lane or code decode at the first pixel that exercises it.

// File: rtl/pix_clamp_pkg.sv
package pix_clamp_pkg;
  localparam int CW = 12;
  typedef logic [CW-1:0] comp_t;
  typedef enum logic [2:0] {
    RC_PASS = 3'd0, RC_D8 = 3'd1, RC_D10 = 3'd2, RC_D12 = 3'd3, RC_PROG = 3'd7
  } range_code_e;
  localparam comp_t D8_LO  = comp_t'(16  << 4);
  localparam comp_t D8_HI  = comp_t'(235 << 4);
  localparam comp_t D10_LO = comp_t'(64  << 2);
  localparam comp_t D10_HI = comp_t'(940 << 2);
  localparam comp_t D12_LO = comp_t'(256);
  localparam comp_t D12_HI = comp_t'(3760);
  localparam comp_t PROG_LO_DEFAULT = comp_t'(12'h010);
  localparam comp_t PROG_HI_DEFAULT = comp_t'(12'hFEF);
endpackage

// File: rtl/pix_range_sel.sv
module pix_range_sel
  import pix_clamp_pkg::*;
#(parameter int NCH = 3)
(
  input  logic               en,
  input  logic [2:0]         code,
  input  comp_t [NCH-1:0]    prog_lo,
  input  comp_t [NCH-1:0]    prog_hi,
  output logic               active,
  output comp_t [NCH-1:0]    lo,
  output comp_t [NCH-1:0]    hi
);
  always_comb begin
    active = en;
    for (int i = 0; i < NCH; i++) begin
      lo[i] = '0;
      hi[i] = '1;
    end
    unique case (code)
      RC_D8:   for (int i = 0; i < NCH; i++) begin lo[i] = D8_LO;  hi[i] = D8_HI;  end
      RC_D10:  for (int i = 0; i < NCH; i++) begin lo[i] = D10_LO; hi[i] = D10_HI; end
      RC_D12:  for (int i = 0; i < NCH; i++) begin lo[i] = D12_LO; hi[i] = D12_HI; end
      RC_PROG: for (int i = 0; i < NCH; i++) begin lo[i] = prog_lo[i]; hi[i] = prog_hi[i]; end
      default: active = 1'b0;
    endcase
  end
endmodule

// File: rtl/pix_lane_bound.sv
module pix_lane_bound
  import pix_clamp_pkg::*;
(
  input  logic  active,
  input  comp_t x,
  input  comp_t lo,
  input  comp_t hi,
  output comp_t y
);
  comp_t capped;
  always_comb begin
    capped = (x > hi) ? hi : x;
    if (!active)          y = x;
    else if (lo > hi)     y = hi;
    else if (capped < lo) y = lo;
    else                  y = capped;
  end
endmodule

// File: rtl/pix_range_clamp.sv
module pix_range_clamp
  import pix_clamp_pkg::*;
#(parameter int NCH = 3)
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [11:0] in_r,
  input  logic [11:0] in_g,
  input  logic [11:0] in_b,
  input  logic        clamp_en,
  input  logic [2:0]  range_code,
  input  logic [11:0] lim_lo_r,
  input  logic [11:0] lim_hi_r,
  input  logic [11:0] lim_lo_g,
  input  logic [11:0] lim_hi_g,
  input  logic [11:0] lim_lo_b,
  input  logic [11:0] lim_hi_b,
  output logic        out_vld,
  output logic [11:0] out_r,
  output logic [11:0] out_g,
  output logic [11:0] out_b
);
  comp_t [NCH-1:0] x_in, lo_s, hi_s, plo, phi, y_nxt, y_q;
  logic active;
  logic vld_q;

  assign x_in = {in_b, in_g, in_r};
  assign plo  = {lim_lo_b, lim_lo_g, lim_lo_r};
  assign phi  = {lim_hi_b, lim_hi_g, lim_hi_r};

  pix_range_sel #(.NCH(NCH)) u_sel (
    .en(clamp_en), .code(range_code), .prog_lo(plo), .prog_hi(phi),
    .active(active), .lo(lo_s), .hi(hi_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    pix_lane_bound u_lane (
      .active(active), .x(x_in[c]), .lo(lo_s[c]), .hi(hi_s[c]), .y(y_nxt[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      y_q   <= '0;
    end else begin
      vld_q <= in_vld;
      y_q   <= y_nxt;
    end
  end

  assign out_vld = vld_q;
  assign out_r = y_q[0];
  assign out_g = y_q[1];
  assign out_b = y_q[2];
endmodule

// File: rtl/pix_range_clamp_chk.sv
module pix_range_clamp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [11:0] in_r,
  input logic [11:0] in_g,
  input logic        clamp_en,
  input logic [2:0]  range_code,
  input logic [11:0] lim_lo_g,
  input logic [11:0] lim_hi_g,
  input logic        out_vld,
  input logic [11:0] out_r,
  input logic [11:0] out_g
);
  assert_vld_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld));
  assert_pass_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_en |=> out_r == $past(in_r));
  assert_pass_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && range_code inside {3'd0, 3'd4, 3'd5, 3'd6}) |=> out_g == $past(in_g));
  assert_d8_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && range_code == 3'd1) |=> (out_r >= 12'd256 && out_r <= 12'd3760));
  assert_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && range_code == 3'd7 && lim_lo_g <= lim_hi_g)
      |=> (out_g >= $past(lim_lo_g) && out_g <= $past(lim_hi_g)));
  assert_inverted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && range_code == 3'd7 && lim_lo_g > lim_hi_g) |=> out_g == $past(lim_hi_g));
  always @(posedge clk)
    if (!rst_n) assert_reset_R1: assert (out_vld == 1'b0 || $isunknown(out_vld));
endmodule

bind pix_range_clamp pix_range_clamp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_r(in_r), .in_g(in_g),
  .clamp_en(clamp_en), .range_code(range_code), .lim_lo_g(lim_lo_g),
  .lim_hi_g(lim_hi_g), .out_vld(out_vld), .out_r(out_r), .out_g(out_g)
);

// File: tb/sim_pix_range_clamp.sv
module sim_pix_range_clamp;
  logic clk = 0, rst_n = 0;
  logic in_vld = 0, clamp_en = 0;
  logic [11:0] in_r = 0, in_g = 0, in_b = 0;
  logic [2:0] range_code = 0;
  logic [11:0] lim_lo_r = 12'h010, lim_hi_r = 12'hFEF, lim_lo_g = 12'h010,
               lim_hi_g = 12'hFEF, lim_lo_b = 12'h010, lim_hi_b = 12'hFEF;
  logic out_vld;
  logic [11:0] out_r, out_g, out_b;
  int checks = 0, fails = 0, cyc = 0;
  int exp_v, exp_r, exp_g, exp_b;
  logic have_exp = 0;

  always #5 clk = ~clk;

  pix_range_clamp u0 (.*);

  function automatic int model(int x, int lo, int hi, bit en, int code);
    int l, h;
    if (!en) return x;
    case (code)
      1: begin l = 16*16; h = 235*16; end
      2: begin l = 64*4;  h = 940*4;  end
      3: begin l = 256;   h = 3760;   end
      7: begin l = lo;    h = hi;     end
      default: return x;
    endcase
    if (l > h) return h;
    if (x > h) return h;
    if (x < l) return l;
    return x;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Model runs on every clock: expected output for the next cycle.
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      exp_v = in_vld;
      exp_r = model(in_r, lim_lo_r, lim_hi_r, clamp_en, range_code);
      exp_g = model(in_g, lim_lo_g, lim_hi_g, clamp_en, range_code);
      exp_b = model(in_b, lim_lo_b, lim_hi_b, clamp_en, range_code);
      have_exp = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && have_exp) begin
      chk("R2 vld", out_vld, exp_v);
      chk("R3-R11 r", out_r, exp_r);
      chk("R3-R11 g", out_g, exp_g);
      chk("R3-R11 b", out_b, exp_b);
    end
  end

  task automatic drive(bit v, bit en, int code, int r, int g, int b);
    @(negedge clk);
    in_vld = v; clamp_en = en; range_code = code[2:0];
    in_r = r[11:0]; in_g = g[11:0]; in_b = b[11:0];
  endtask

  task automatic expect_next(string req, int r, int g, int b);
    @(negedge clk); #1;
    chk(req, out_r, r); chk(req, out_g, g); chk(req, out_b, b);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 vld", out_vld, 0); chk("R1 r", out_r, 0); chk("R1 b", out_b, 0);
        rst_n = 1;
        // R3: disabled, any code passes
        drive(1, 0, 1, 0, 4095, 100); expect_next("R3", 0, 4095, 100);
        // R4: code 0 and undefined codes pass
        drive(1, 1, 0, 5, 4090, 7);   expect_next("R4", 5, 4090, 7);
        drive(1, 1, 5, 1, 4095, 200); expect_next("R4", 1, 4095, 200);
        // R5 8-bit range
        drive(1, 1, 1, 0, 4095, 1000); expect_next("R5", 256, 3760, 1000);
        // R6 10-bit range
        drive(0, 1, 2, 255, 3761, 256); expect_next("R6", 256, 3760, 256);
        // R7 12-bit range
        drive(1, 1, 3, 3760, 10, 4000); expect_next("R7", 3760, 256, 3760);
        // R10 defaults with R8 programmable
        drive(1, 1, 7, 0, 4095, 2048); expect_next("R10", 16, 4079, 2048);
        // R8, R11 per-channel limits
        @(negedge clk);
        lim_lo_r = 100; lim_hi_r = 200; lim_lo_g = 1000; lim_hi_g = 1100;
        lim_lo_b = 0; lim_hi_b = 4095;
        in_r = 50; in_g = 1200; in_b = 4095;
        expect_next("R8 R11", 100, 1100, 4095);
        // R9 inverted limits
        drive(1, 1, 7, 50, 1200, 4095);
        lim_lo_g = 3000; lim_hi_g = 500;
        expect_next("R9", 100, 500, 4095);
        // sweep with model-based compare
        for (int i = 0; i < 400; i++)
          drive(i[0], i[1], i % 8, (i * 37) % 4096, (i * 911) % 4096, (i * 53) % 4096);
        drive(0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule